// File: doc/BRIEF.md
# Dual-Path Maskable Interrupt Controller with Source Elevation

This block collects 32 interrupt inputs into a source word and gates that word through two independent enable masks. One mask feeds a normal request line and the other feeds a fast request line. For each path a priority encoder reports the highest enabled active source as an index with a valid flag. Software reads and writes the controller through a simple synchronous register port. Writes take effect at the clock edge, and reads are combinational from the addressed register.

Six source positions are tied high. Software can therefore raise an interrupt on demand just by setting the matching enable bit. A control register can elevate one chosen source above everything else. When that source is active, fast-enabled and the elevation enable is set, a dedicated output rises and the vector output carries a 7-bit vector that software programmed. The control register also keeps a break-request bit and a debug-request bit. Software can read both back, but they have no effect inside the block.

Register map (word address on `addr_i`):
- 0: source word (read only)
- 1: normal enable
- 2: fast enable
- 3: normal pending (read only)
- 4: fast pending (read only)
- 5: control
- 6 and 7: unmapped

Top module: `intc_elev`

## Requirements
- R1: Source bits 0, 1, 2, 29, 30 and 31 always read as 1 at address 0, from reset onward.
- R2: Every other source bit equals the raw input as sampled at the second rising clock edge before the read; it passes through a two-flop synchroniser.
- R3: `norm_req_o` is 1 exactly when some source bit and the same bit of the normal enable (address 1) are both 1.
- R4: `fast_req_o` is 1 exactly when some source bit and the same bit of the fast enable (address 2) are both 1.
- R5: The normal pending register (address 3) and the fast pending register (address 4) each read as follows. When at least one masked source is active, bit 5 is 1 and bits 4:0 hold the highest active index; a higher index wins. Otherwise the register reads 0. Bits 31:6 are always 0.
- R6: The control register (address 5) keeps only these bits: bit 16 (break request), bit 15 (elevation enable), bit 14 (debug request), bits 11:7 (selected source) and bits 6:0 (vector). Bits 31:17 and 13:12 read 0 whatever was written.
- R7: `promo_o` is 1 exactly when control bit 15 is 1 and the selected source bit and its fast enable bit are both 1. While `promo_o` is 1, `vec_o` equals control bits 6:0.
- R8: When `promo_o` is 0, `vec_o` takes one of three values. If the fast path is active, it is {2'b10, fast index}. Otherwise, if the normal path is active, it is {2'b01, normal index}. Otherwise it is 0.
- R9: Reset clears both enables, the control register and the synchroniser.
- R10: Addresses 6 and 7 read 0. Writes to addresses 0, 3, 4, 6 and 7 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_i | input | 32 | Raw interrupt inputs |
| norm_req_o | output | 1 | Normal request |
| fast_req_o | output | 1 | Fast request |
| promo_o | output | 1 | Elevated source active |
| vec_o | output | 7 | Service vector |

## Verification
On every cycle the assertions check the following:
- the tied-high source bits are set;
- the unused control bits stay clear;
- each request line agrees with the valid flag of its own pending encoder;
- a reported normal index really is an enabled active source;
- elevation only occurs with the enable bit set and a fast request present, and it always drives the programmed vector.

The bench's scenarios show the rest:
- the two-cycle input latency;
- which index wins when several sources are active;
- the fallback ordering of the vector when there is no elevation;
- that writes to read-only and unmapped addresses are ignored.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned SRC_W = 32;
  localparam int unsigned IDX_W = $clog2(SRC_W);
  localparam int unsigned VEC_W = 7;
  localparam int unsigned ADDR_W = 3;
  localparam logic [SRC_W-1:0] FORCED_MASK = 32'hE000_0007;
  localparam logic [31:0] CTRL_MASK = 32'h0001_CFFF;
  localparam int unsigned CTRL_EN_BIT = 15;
  localparam int unsigned CTRL_SEL_LO = 7;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SRC   = 3'd0,
    ADDR_NEN   = 3'd1,
    ADDR_FEN   = 3'd2,
    ADDR_NPEND = 3'd3,
    ADDR_FPEND = 3'd4,
    ADDR_CTRL  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  act_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  // ascending scan: last hit is highest index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (act_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [IDX_W:0]    npend_i,
  input  logic [IDX_W:0]    fpend_i,
  output logic [SRC_W-1:0]  nen_o,
  output logic [SRC_W-1:0]  fen_o,
  output logic [31:0]       ctrl_o,
  output logic [31:0]       rdata_o
);
  logic [SRC_W-1:0] nen_q, fen_q;
  logic [31:0]      ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nen_q  <= '0;
      fen_q  <= '0;
      ctrl_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        ADDR_NEN:  nen_q  <= wdata_i[SRC_W-1:0];
        ADDR_FEN:  fen_q  <= wdata_i[SRC_W-1:0];
        ADDR_CTRL: ctrl_q <= wdata_i & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_SRC:   rdata_o = 32'(src_i);
      ADDR_NEN:   rdata_o = 32'(nen_q);
      ADDR_FEN:   rdata_o = 32'(fen_q);
      ADDR_NPEND: rdata_o = 32'(npend_i);
      ADDR_FPEND: rdata_o = 32'(fpend_i);
      ADDR_CTRL:  rdata_o = ctrl_q;
      default:    rdata_o = '0;
    endcase
  end

  assign nen_o  = nen_q;
  assign fen_o  = fen_q;
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/intc_elev.sv
module intc_elev
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [SRC_W-1:0]  irq_i,
  output logic              norm_req_o,
  output logic              fast_req_o,
  output logic              promo_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [SRC_W-1:0] sync_q, src, nen, fen;
  logic [31:0]      ctrl;
  logic [IDX_W:0]   npend, fpend;
  logic [IDX_W-1:0] sel;

  intc_sync #(.W(SRC_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(sync_q)
  );

  assign src = sync_q | FORCED_MASK;

  intc_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .src_i(src), .npend_i(npend), .fpend_i(fpend),
    .nen_o(nen), .fen_o(fen), .ctrl_o(ctrl), .rdata_o(rdata_o)
  );

  intc_prio #(.W(SRC_W)) u_nprio (
    .act_i(src & nen), .valid_o(npend[IDX_W]), .idx_o(npend[IDX_W-1:0])
  );

  intc_prio #(.W(SRC_W)) u_fprio (
    .act_i(src & fen), .valid_o(fpend[IDX_W]), .idx_o(fpend[IDX_W-1:0])
  );

  assign norm_req_o = |(src & nen);
  assign fast_req_o = |(src & fen);

  assign sel     = ctrl[CTRL_SEL_LO +: IDX_W];
  assign promo_o = ctrl[CTRL_EN_BIT] & src[sel] & fen[sel];

  always_comb begin
    if (promo_o)             vec_o = ctrl[VEC_W-1:0];
    else if (fpend[IDX_W])   vec_o = {2'b10, fpend[IDX_W-1:0]};
    else if (npend[IDX_W])   vec_o = {2'b01, npend[IDX_W-1:0]};
    else                     vec_o = '0;
  end
endmodule

// File: rtl/intc_elev_chk.sv
module intc_elev_chk
  import intc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SRC_W-1:0]  src,
  input logic [SRC_W-1:0]  nen,
  input logic [31:0]       ctrl,
  input logic [IDX_W:0]    npend,
  input logic [IDX_W:0]    fpend,
  input logic              norm_req_o,
  input logic              fast_req_o,
  input logic              promo_o,
  input logic [VEC_W-1:0]  vec_o
);
  a_r1_forced_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src & FORCED_MASK) == FORCED_MASK);

  a_r6_ctrl_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl & ~CTRL_MASK) == 32'h0);

  a_r3_norm_matches_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_req_o == npend[IDX_W]);

  a_r4_fast_matches_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_req_o == fpend[IDX_W]);

  a_r5_norm_idx_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    npend[IDX_W] |-> (src[npend[IDX_W-1:0]] && nen[npend[IDX_W-1:0]]));

  a_r7_promo_needs_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promo_o |-> (fast_req_o && ctrl[CTRL_EN_BIT]));

  a_r7_promo_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    promo_o |-> vec_o == ctrl[VEC_W-1:0]);
endmodule

bind intc_elev intc_elev_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src(src), .nen(nen), .ctrl(ctrl),
  .npend(npend), .fpend(fpend), .norm_req_o(norm_req_o),
  .fast_req_o(fast_req_o), .promo_o(promo_o), .vec_o(vec_o)
);

// File: tb/intc_elev_bench.sv
`timescale 1ns/1ps
module intc_elev_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] irq = '0;
  logic [31:0] rdata;
  logic        norm_req, fast_req, promo;
  logic [6:0]  vec;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intc_elev u_intc_elev (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_i(irq), .norm_req_o(norm_req), .fast_req_o(fast_req),
    .promo_o(promo), .vec_o(vec)
  );

  // behavioural reference
  logic [31:0] m_stage[2];
  logic [31:0] m_nen, m_fen, m_ctrl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage[0] = '0; m_stage[1] = '0;
      m_nen = '0; m_fen = '0; m_ctrl = '0;
    end else begin
      m_stage[1] = m_stage[0];
      m_stage[0] = irq;
      if (wr) begin
        if (addr == 3'd1) m_nen = wdata;
        if (addr == 3'd2) m_fen = wdata;
        if (addr == 3'd5) m_ctrl = wdata & 32'h0001_CFFF;
      end
    end
  end

  function automatic logic [31:0] m_src();
    logic [31:0] s = m_stage[1];
    for (int i = 0; i < 32; i++)
      if (i <= 2 || i >= 29) s[i] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] pend_of(input logic [31:0] v);
    logic [31:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (v[i]) p = 32'h20 + 32'(i);
    return p;
  endfunction

  function automatic logic m_promo();
    int s = int'(m_ctrl[11:7]);
    return m_ctrl[15] && m_src() [s] && m_fen[s];
  endfunction

  function automatic logic [6:0] m_vec();
    logic [31:0] fp = pend_of(m_src() & m_fen);
    logic [31:0] np = pend_of(m_src() & m_nen);
    if (m_promo()) return m_ctrl[6:0];
    if (fp != 0) return {2'b10, fp[4:0]};
    if (np != 0) return {2'b01, np[4:0]};
    return 7'd0;
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_src();
      3'd1: return m_nen;
      3'd2: return m_fen;
      3'd3: return pend_of(m_src() & m_nen);
      3'd4: return pend_of(m_src() & m_fen);
      3'd5: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      if (!rst_n) begin
        chk("R9 rdata in reset", rdata, m_read(addr));
        chk("R9 promo in reset", 32'(promo), 32'(m_promo()));
      end else begin
        chk("R3 norm_req", 32'(norm_req), 32'(|(m_src() & m_nen)));
        chk("R4 fast_req", 32'(fast_req), 32'(|(m_src() & m_fen)));
        chk("R7 promo", 32'(promo), 32'(m_promo()));
        chk("R8/R7 vec", 32'(vec), 32'(m_vec()));
        case (addr)
          3'd0: chk("R1/R2 source read", rdata, m_read(addr));
          3'd3, 3'd4: chk("R5 pending read", rdata, m_read(addr));
          3'd5: chk("R6 control read", rdata, m_read(addr));
          3'd6, 3'd7: chk("R10 unmapped read", rdata, m_read(addr));
          default: chk("R9 enable read", rdata, m_read(addr));
        endcase
      end
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d; step();
    wr = 1'b0; step();
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n);
    addr = a;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    addr = 3'd5;
    repeat (3) step();
    rst_n = 1'b1;
    rd_reg(3'd0, 2);                 // R1 forced bits after reset
    irq = 32'h0000_0020;
    rd_reg(3'd0, 3);                 // R2 latency
    wr_reg(3'd1, 32'h0000_0020);     // R3 normal on bit 5
    rd_reg(3'd3, 2);
    wr_reg(3'd1, 32'h4000_0028);     // R5 higher index wins (30)
    rd_reg(3'd3, 2);
    irq = 32'h0000_0420;
    wr_reg(3'd2, 32'h0000_0400);     // R4 fast on bit 10
    rd_reg(3'd4, 2);
    wr_reg(3'd5, 32'h0000_8555);     // R7 elevate source 10 (sel=10, vec 0x55)
    rd_reg(3'd5, 2);
    irq = 32'h0000_0020;             // drop bit 10: elevation falls after 2 cycles
    rd_reg(3'd5, 3);
    wr_reg(3'd5, 32'hFFFF_FFFF);     // R6 mask; sel 31, fen[31]=0
    rd_reg(3'd5, 2);
    wr_reg(3'd2, 32'hFFFF_FFFF);     // R7 forced bit 31 elevated
    rd_reg(3'd4, 2);
    wr_reg(3'd0, 32'h0);             // R10 read-only writes ignored
    wr_reg(3'd3, 32'h0);
    wr_reg(3'd6, 32'h1234_5678);
    rd_reg(3'd6, 1);
    rd_reg(3'd7, 1);
    rd_reg(3'd1, 1);
    wr_reg(3'd2, 32'h0);             // R8 normal fallback
    wr_reg(3'd1, 32'h0);
    rd_reg(3'd3, 2);                 // R8 zero vector
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irq  = lfsr & 32'h1FFF_FFF8;
      addr = lfsr[10:8];
      wr   = (lfsr[15:13] == 3'd0);
      wdata = {lfsr[7:0], lfsr[31:8]};
      step();
    end
    wr = 1'b0;
    rst_n = 1'b0;                    // R9 mid-run reset
    addr = 3'd2;
    repeat (2) step();
    rst_n = 1'b1;
    rd_reg(3'd5, 2);
    rd_reg(3'd1, 1);
    finish_run();
  end
endmodule